// File: doc/BRIEF.md
# Coincidence Histogram Acquisition Sequencer

This block sequences acquisition for a two-spectrum multichannel analyser fed by a pulse-shape classifier. After a host start strobe it clears its elapsed-time counters, then waits for a trigger. For each triggered pulse it follows the three integration windows (reported by done inputs from an external integrator) and aborts if a second trigger arrives while integrating. After the last sum it waits out the classifier latency and then samples the coincidence flag. Events that are not coincident are discarded. For coincident events it performs a read, increment and write on two histogram memories: one indexed by the beta area and one by the gamma area.

Each area is scaled to a bin address by its own gain setting. Two wide time counters record elapsed real time and live time, and only the upper part of each is reported. While the sequencer is stopped, a host port can read any bin pair at any time and can zero both histograms.

Top module: `coinc_hist_seq`

## Requirements
- R1: After reset the sequencer is stopped, and both reported time values are 0 and stay 0 while stopped.
- R2: A one-cycle start strobe in the stopped state passes through one clearing cycle that zeroes both time counters, then enters the idle-wait state.
- R3: In idle-wait the sequencer stays until trigger is high. It then passes one baseline cycle and three integration windows, each held until its done input (sum1Done, sum2Done, sum3Done) is high and followed by one latch cycle.
- R4: A trigger seen during any integration window or latch cycle returns the sequencer to idle-wait, and neither histogram changes.
- R5: After the third latch cycle and one hand-off cycle, the sequencer waits exactly WAIT_CYCLES cycles (default 34) and then samples coinFlag and both areas. A low flag returns it to idle-wait with no histogram change.
- R6: A bin address is the area shifted right by its 4-bit gain (0 to 15). Results above 4095 saturate at bin 4095.
- R7: A coincident event adds one to the addressed beta bin and one to the addressed gamma bin, using address, read, increment and write cycles.
- R8: A bin holding the all-ones value keeps that value when incremented.
- R9: A stop strobe seen at any time while running is held pending. The sequencer then stops at the end of the next histogram write. Without a pending stop it returns to idle-wait.
- R10: The real counter advances in every running state. The live counter advances only from idle-wait through the third integration window. Both are TIME_W bits wide and report their upper 32 bits. Neither moves while stopped.
- R11: betaBinData and gammaBinData return the contents of bin hostAddr one clock after the address is applied, at any time.
- R12: A hostClear strobe while stopped zeroes every bin of both histograms over 4096 cycles. Start is not accepted during the clear, and hostClear is ignored while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start strobe from host |
| stopReq | input | 1 | Stop request strobe from host |
| hostClear | input | 1 | Histogram clear strobe, honoured only when stopped |
| trigger | input | 1 | Pulse trigger; also a pileup indication while integrating |
| sum1Done | input | 1 | First integration window reached |
| sum2Done | input | 1 | Second integration window reached |
| sum3Done | input | 1 | Third integration window reached |
| coinFlag | input | 1 | Classifier coincidence result |
| betaArea | input | AREA_W | Beta pulse area |
| gammaArea | input | AREA_W | Gamma pulse area |
| betaGain | input | GAIN_W | Beta right-shift setting |
| gammaGain | input | GAIN_W | Gamma right-shift setting |
| hostAddr | input | ADDR_W | Host read bin address |
| betaBinData | output | BIN_W | Beta bin contents, one cycle after address |
| gammaBinData | output | BIN_W | Gamma bin contents, one cycle after address |
| realTime | output | TIME_OUT_W | Upper bits of the real-time counter |
| liveTime | output | TIME_OUT_W | Upper bits of the live-time counter |

## Verification
A vector table drives events with different gain pairs, areas below, at and above the bin range, repeated addresses and low coincidence flags. These vectors separate an error in the shift from an error in saturation, and separate a wrong update from a missing one. Directed runs hold a done input low so that a second trigger lands inside a window, and they push one bin past full to show that it saturates rather than wraps. Further runs issue a clear while running and while stopped. A final start-to-stop event with a known path checks exact real and live counts, which tell the live-state subset and the wait length apart from the rest of the sequence.

// File: rtl/coinc_hist_pkg.sv
package coinc_hist_pkg;

  typedef enum logic [4:0] {
    ST_STOP, ST_RESET, ST_START, ST_RD_BASE,
    ST_CNT1, ST_RD_S1, ST_CNT2, ST_RD_S2, ST_CNT3, ST_RD_S3,
    ST_DIFF, ST_WAIT, ST_COIN,
    ST_SET_ADDR, ST_RD_BIN, ST_INC_BIN, ST_WR_BIN
  } seq_state_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic clrTime;
    logic runReal;
    logic runLive;
    logic capArea;
    logic setAddr;
    logic rdBin;
    logic incBin;
    logic wrBin;
    logic clrStart;
  } seq_cmd_t;

endpackage

// File: rtl/coinc_hist_ctrl.sv
module coinc_hist_ctrl
  import coinc_hist_pkg::*;
#(
  parameter int WAIT_CYCLES = 34
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     startReq,
  input  logic     stopReq,
  input  logic     hostClear,
  input  logic     trigger,
  input  logic     sum1Done,
  input  logic     sum2Done,
  input  logic     sum3Done,
  input  logic     coinFlag,
  input  logic     clrBusy,
  output seq_cmd_t cmd
);

  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);

  seq_state_e  state, stateNext;
  logic [WAIT_W-1:0] waitCnt;
  logic        stopPend;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_STOP:     if (startReq && !clrBusy) stateNext = ST_RESET;
      ST_RESET:    stateNext = ST_START;
      ST_START:    if (trigger) stateNext = ST_RD_BASE;
      ST_RD_BASE:  stateNext = ST_CNT1;
      ST_CNT1:     if (trigger) stateNext = ST_START; else if (sum1Done) stateNext = ST_RD_S1;
      ST_RD_S1:    stateNext = trigger ? ST_START : ST_CNT2;
      ST_CNT2:     if (trigger) stateNext = ST_START; else if (sum2Done) stateNext = ST_RD_S2;
      ST_RD_S2:    stateNext = trigger ? ST_START : ST_CNT3;
      ST_CNT3:     if (trigger) stateNext = ST_START; else if (sum3Done) stateNext = ST_RD_S3;
      ST_RD_S3:    stateNext = trigger ? ST_START : ST_DIFF;
      ST_DIFF:     stateNext = ST_WAIT;
      ST_WAIT:     if (waitCnt == WAIT_W'(WAIT_CYCLES - 1)) stateNext = ST_COIN;
      ST_COIN:     stateNext = coinFlag ? ST_SET_ADDR : ST_START;
      ST_SET_ADDR: stateNext = ST_RD_BIN;
      ST_RD_BIN:   stateNext = ST_INC_BIN;
      ST_INC_BIN:  stateNext = ST_WR_BIN;
      ST_WR_BIN:   stateNext = stopPend ? ST_STOP : ST_START;
      default:     stateNext = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_STOP;
      waitCnt  <= '0;
      stopPend <= 1'b0;
    end else begin
      state    <= stateNext;
      waitCnt  <= (state == ST_WAIT) ? waitCnt + WAIT_W'(1) : '0;
      if (state == ST_STOP)  stopPend <= 1'b0;
      else if (stopReq)      stopPend <= 1'b1;
    end
  end

  always_comb begin
    cmd          = '0;
    cmd.clrTime  = (state == ST_RESET);
    cmd.runReal  = (state != ST_STOP) && (state != ST_RESET);
    cmd.runLive  = (state inside {ST_START, ST_RD_BASE, ST_CNT1, ST_RD_S1,
                                  ST_CNT2, ST_RD_S2, ST_CNT3});
    cmd.capArea  = (state == ST_COIN);
    cmd.setAddr  = (state == ST_SET_ADDR);
    cmd.rdBin    = (state == ST_RD_BIN);
    cmd.incBin   = (state == ST_INC_BIN);
    cmd.wrBin    = (state == ST_WR_BIN);
    cmd.clrStart = (state == ST_STOP) && hostClear;
  end

  // R1: idle without start
  a_r1_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && !startReq) |=> state == ST_STOP);
  // R2: clearing cycle only entered from stop
  a_r2_reset_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET) |-> $past(state) == ST_STOP);
  // R4: pileup abort
  a_r4_pileup_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ((state inside {ST_CNT1, ST_RD_S1, ST_CNT2, ST_RD_S2, ST_CNT3, ST_RD_S3}) && trigger)
    |=> state == ST_START);
  // R5: rejected event
  a_r5_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COIN && !coinFlag) |=> state == ST_START);
  // R9: pending stop honoured after write
  a_r9_stop_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_BIN && stopPend) |=> state == ST_STOP);
  // R12: sweep only while stopped
  a_r12_clear_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    clrBusy |-> state == ST_STOP);

endmodule

// File: rtl/coinc_hist_bank.sv
module coinc_hist_bank #(
  parameter int AREA_W = 16,
  parameter int ADDR_W = 12,
  parameter int BIN_W  = 32,
  parameter int GAIN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capArea,
  input  logic              setAddr,
  input  logic              rdBin,
  input  logic              incBin,
  input  logic              wrBin,
  input  logic              clrActive,
  input  logic [ADDR_W-1:0] clrAddr,
  input  logic [AREA_W-1:0] area,
  input  logic [GAIN_W-1:0] gain,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic [BIN_W-1:0]  hostData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BIN_W-1:0]  mem [DEPTH];
  logic [AREA_W-1:0] areaQ, shifted;
  logic [ADDR_W-1:0] binAddr, mapped;
  logic [BIN_W-1:0]  rdQ, incQ;

  assign shifted = areaQ >> gain;
  assign mapped  = (shifted > AREA_W'(DEPTH - 1)) ? '1 : shifted[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      areaQ   <= '0;
      binAddr <= '0;
      rdQ     <= '0;
      incQ    <= '0;
    end else begin
      if (capArea) areaQ   <= area;
      if (setAddr) binAddr <= mapped;
      if (rdBin)   rdQ     <= mem[binAddr];
      if (incBin)  incQ    <= (&rdQ) ? rdQ : rdQ + BIN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (clrActive)  mem[clrAddr] <= '0;
    else if (wrBin) mem[binAddr] <= incQ;
    hostData <= mem[hostAddr];
  end

  // R8: an incremented bin never wraps to zero
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrBin |-> incQ != '0);

endmodule

// File: rtl/coinc_hist_dp.sv
module coinc_hist_dp
  import coinc_hist_pkg::*;
#(
  parameter int AREA_W     = 16,
  parameter int ADDR_W     = 12,
  parameter int BIN_W      = 32,
  parameter int GAIN_W     = 4,
  parameter int TIME_W     = 49,
  parameter int TIME_OUT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  seq_cmd_t              cmd,
  input  logic [1:0][AREA_W-1:0] areaIn,
  input  logic [1:0][GAIN_W-1:0] gainIn,
  input  logic [ADDR_W-1:0]     hostAddr,
  output logic [1:0][BIN_W-1:0] binOut,
  output logic                  clrBusy,
  output logic [TIME_OUT_W-1:0] realTime,
  output logic [TIME_OUT_W-1:0] liveTime
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [TIME_W-1:0] realCnt, liveCnt;
  logic [ADDR_W-1:0] clrAddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      realCnt <= '0;
      liveCnt <= '0;
      clrBusy <= 1'b0;
      clrAddr <= '0;
    end else begin
      if (cmd.clrTime) begin
        realCnt <= '0;
        liveCnt <= '0;
      end else begin
        if (cmd.runReal) realCnt <= realCnt + TIME_W'(1);
        if (cmd.runLive) liveCnt <= liveCnt + TIME_W'(1);
      end
      if (clrBusy) begin
        clrAddr <= clrAddr + ADDR_W'(1);
        if (clrAddr == ADDR_W'(DEPTH - 1)) clrBusy <= 1'b0;
      end else if (cmd.clrStart) begin
        clrBusy <= 1'b1;
        clrAddr <= '0;
      end
    end
  end

  assign realTime = realCnt[TIME_W-1 -: TIME_OUT_W];
  assign liveTime = liveCnt[TIME_W-1 -: TIME_OUT_W];

  for (genvar h = 0; h < 2; h++) begin : g_bank
    coinc_hist_bank #(
      .AREA_W(AREA_W), .ADDR_W(ADDR_W), .BIN_W(BIN_W), .GAIN_W(GAIN_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .capArea(cmd.capArea), .setAddr(cmd.setAddr), .rdBin(cmd.rdBin),
      .incBin(cmd.incBin), .wrBin(cmd.wrBin),
      .clrActive(clrBusy), .clrAddr(clrAddr),
      .area(areaIn[h]), .gain(gainIn[h]),
      .hostAddr(hostAddr), .hostData(binOut[h])
    );
  end

  // R10: live time never exceeds real time
  a_r10_live_le_real: assert property (@(posedge clk) disable iff (!rst_n)
    liveCnt <= realCnt);
  // R10: real counter frozen when not running
  a_r10_real_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.runReal && !cmd.clrTime) |=> $stable(realCnt));

endmodule

// File: rtl/coinc_hist_seq.sv
module coinc_hist_seq
  import coinc_hist_pkg::*;
#(
  parameter int AREA_W      = 16,
  parameter int ADDR_W      = 12,
  parameter int BIN_W       = 32,
  parameter int GAIN_W      = 4,
  parameter int TIME_W      = 49,
  parameter int TIME_OUT_W  = 32,
  parameter int WAIT_CYCLES = 34
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  startReq,
  input  logic                  stopReq,
  input  logic                  hostClear,
  input  logic                  trigger,
  input  logic                  sum1Done,
  input  logic                  sum2Done,
  input  logic                  sum3Done,
  input  logic                  coinFlag,
  input  logic [AREA_W-1:0]     betaArea,
  input  logic [AREA_W-1:0]     gammaArea,
  input  logic [GAIN_W-1:0]     betaGain,
  input  logic [GAIN_W-1:0]     gammaGain,
  input  logic [ADDR_W-1:0]     hostAddr,
  output logic [BIN_W-1:0]      betaBinData,
  output logic [BIN_W-1:0]      gammaBinData,
  output logic [TIME_OUT_W-1:0] realTime,
  output logic [TIME_OUT_W-1:0] liveTime
);

  seq_cmd_t                cmd;
  logic                    clrBusy;
  logic [1:0][BIN_W-1:0]   binOut;

  coinc_hist_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .stopReq(stopReq),
    .hostClear(hostClear), .trigger(trigger), .sum1Done(sum1Done),
    .sum2Done(sum2Done), .sum3Done(sum3Done), .coinFlag(coinFlag),
    .clrBusy(clrBusy), .cmd(cmd)
  );

  coinc_hist_dp #(
    .AREA_W(AREA_W), .ADDR_W(ADDR_W), .BIN_W(BIN_W), .GAIN_W(GAIN_W),
    .TIME_W(TIME_W), .TIME_OUT_W(TIME_OUT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .areaIn({gammaArea, betaArea}), .gainIn({gammaGain, betaGain}),
    .hostAddr(hostAddr), .binOut(binOut), .clrBusy(clrBusy),
    .realTime(realTime), .liveTime(liveTime)
  );

  assign betaBinData  = binOut[0];
  assign gammaBinData = binOut[1];

endmodule

// File: tb/test_coinc_hist_seq.sv
module test_coinc_hist_seq;

  localparam int BIN_W = 4;
  localparam int TIME_W = 33;

  logic clk = 1'b0, rst_n = 1'b0;
  logic startReq = 0, stopReq = 0, hostClear = 0, trigger = 0;
  logic sum1Done = 1, sum2Done = 1, sum3Done = 1, coinFlag = 0;
  logic [15:0] betaArea = 0, gammaArea = 0;
  logic [3:0]  betaGain = 0, gammaGain = 0;
  logic [11:0] hostAddr = 0;
  logic [BIN_W-1:0] betaBinData, gammaBinData;
  logic [31:0] realTime, liveTime;

  int checks = 0, errors = 0;
  bit finished = 0;
  int unsigned shB [4096];
  int unsigned shG [4096];

  always #5 clk = ~clk;

  coinc_hist_seq #(.BIN_W(BIN_W), .TIME_W(TIME_W)) i_coinc_hist_seq (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .stopReq(stopReq),
    .hostClear(hostClear), .trigger(trigger), .sum1Done(sum1Done),
    .sum2Done(sum2Done), .sum3Done(sum3Done), .coinFlag(coinFlag),
    .betaArea(betaArea), .gammaArea(gammaArea), .betaGain(betaGain),
    .gammaGain(gammaGain), .hostAddr(hostAddr), .betaBinData(betaBinData),
    .gammaBinData(gammaBinData), .realTime(realTime), .liveTime(liveTime)
  );

  // {betaGain, gammaGain, betaArea, gammaArea, coin, expBetaBin, expGammaBin}
  localparam logic [64:0] VEC [8] = '{
    {4'd0,  4'd0,  16'd100,    16'd200,    1'b1, 12'd100,  12'd200},
    {4'd4,  4'd2,  16'h1230,   16'h0800,   1'b1, 12'd291,  12'd512},
    {4'd15, 4'd15, 16'hFFFF,   16'h8000,   1'b1, 12'd1,    12'd1},
    {4'd0,  4'd3,  16'h2000,   16'hFFFF,   1'b1, 12'd4095, 12'd4095},
    {4'd1,  4'd1,  16'd100,    16'd400,    1'b0, 12'd50,   12'd200},
    {4'd0,  4'd0,  16'd4095,   16'd4095,   1'b1, 12'd4095, 12'd4095},
    {4'd2,  4'd0,  16'd400,    16'd200,    1'b1, 12'd100,  12'd200},
    {4'd0,  4'd0,  16'd50,     16'd60,     1'b0, 12'd50,   12'd60}
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic readBins(input logic [11:0] addr, output int unsigned b, output int unsigned g);
    @(negedge clk) hostAddr = addr;
    @(negedge clk);
    b = betaBinData;
    g = gammaBinData;
  endtask

  task automatic doEvent(input logic coin, input logic [15:0] bA, input logic [15:0] gA);
    @(negedge clk);
    betaArea = bA; gammaArea = gA; coinFlag = coin; trigger = 1;
    @(negedge clk) trigger = 0;
    repeat (55) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int unsigned b, g, b2, g2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state and halted counters
    check("R1 real after reset", realTime, 0);
    check("R1 live after reset", liveTime, 0);
    repeat (10) @(negedge clk);
    check("R1 real stays halted", realTime, 0);

    // R12: clear in stop
    pulse(hostClear);
    repeat (4100) @(negedge clk);
    readBins(12'd100, b, g);
    check("R12 beta bin cleared", b, 0);
    check("R12 gamma bin cleared", g, 0);

    // vector table: R3, R5, R6, R7, R11
    pulse(startReq);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      logic [3:0] gB, gG; logic [15:0] bA, gA; logic c; logic [11:0] eB, eG;
      {gB, gG, bA, gA, c, eB, eG} = VEC[i];
      betaGain = gB; gammaGain = gG;
      doEvent(c, bA, gA);
      if (c) begin shB[eB]++; shG[eG]++; end
      readBins(eB, b, b2);
      readBins(eG, g2, g);
      check(c ? "R6 R7 beta bin" : "R5 rejected beta bin", b, shB[eB]);
      check(c ? "R6 R7 gamma bin" : "R5 rejected gamma bin", g, shG[eG]);
    end

    // R4: pileup abort
    betaGain = 0; gammaGain = 0;
    sum1Done = 0;
    @(negedge clk);
    betaArea = 300; gammaArea = 301; coinFlag = 1; trigger = 1;
    @(negedge clk) trigger = 0;
    @(negedge clk);
    @(negedge clk) trigger = 1;
    @(negedge clk) trigger = 0;
    sum1Done = 1;
    repeat (55) @(negedge clk);
    readBins(12'd300, b, g2);
    readBins(12'd301, b2, g);
    check("R4 beta unchanged after pileup", b, 0);
    check("R4 gamma unchanged after pileup", g, 0);
    doEvent(1'b1, 16'd300, 16'd301);
    readBins(12'd300, b, g2);
    check("R4 back to idle, next event counted", b, 1);

    // R8: saturation
    for (int k = 0; k < 15; k++) doEvent(1'b1, 16'd7, 16'd9);
    readBins(12'd7, b, g2);
    check("R8 beta bin reaches max", b, 15);
    doEvent(1'b1, 16'd7, 16'd9);
    doEvent(1'b1, 16'd7, 16'd9);
    readBins(12'd7, b, g2);
    readBins(12'd9, b2, g);
    check("R8 beta bin saturated", b, 15);
    check("R8 gamma bin saturated", g, 15);

    // R12: clear ignored while running
    pulse(hostClear);
    repeat (20) @(negedge clk);
    readBins(12'd7, b, g2);
    check("R12 clear ignored while running", b, 15);

    // R9: pending stop ends acquisition after write
    pulse(stopReq);
    doEvent(1'b1, 16'd20, 16'd21);
    b = realTime;
    repeat (20) @(negedge clk);
    check("R9 R10 real halted after stop", realTime, b);
    readBins(12'd20, b, g2);
    check("R9 last event written", b, 1);

    // R12: clear while stopped
    pulse(hostClear);
    repeat (4100) @(negedge clk);
    readBins(12'd7, b, g2);
    check("R12 saturated bin cleared", b, 0);
    readBins(12'd4095, b, g);
    check("R12 top bin cleared", g, 0);

    // R2 R10 R5: exact time counts for one accepted event
    @(negedge clk) startReq = 1;
    @(negedge clk) begin startReq = 0; stopReq = 1; trigger = 1; betaArea = 5; gammaArea = 6; coinFlag = 1; end
    @(negedge clk) begin stopReq = 0; end
    check("R2 real cleared", realTime, 0);
    check("R2 live cleared", liveTime, 0);
    @(negedge clk) trigger = 0;
    repeat (60) @(negedge clk);
    // live 7 cycles, real 48 cycles; reported value drops one low bit
    check("R10 live count", liveTime, 3);
    check("R5 R10 real count", realTime, 24);
    readBins(12'd5, b, g2);
    check("R7 event after restart", b, 1);
    finish();
  end

endmodule